// File: doc/BRIEF.md
# Flexible PPS Pulse Controller

This block produces one pulse-per-second style output from a free-running time counter. Software issues a 3-bit command through a one-cycle write strobe, loads a target time, and selects the role a target match plays. A match is taken when the time counter is greater than or equal to the loaded target. Depending on the role, a match can start or stop the output, raise an interrupt, or do both. The output can be a single pulse or a continuous train, set by a programmable interval and a programmable width in clock cycles.

The controller is a state machine with six states. `ST_IDLE` goes to `ST_ARM_ONE` on a single-pulse command and to `ST_ARM_TRN` on a train command. Either armed state falls back to `ST_IDLE` on cancel-start. A control-role match moves `ST_ARM_ONE` to `ST_ONE` and `ST_ARM_TRN` to `ST_TRN`. `ST_ONE` returns to `ST_IDLE` when its width has elapsed, or at once on stop-now. `ST_TRN` goes to `ST_TRN_STOPARM` on stop-at-time and to `ST_IDLE` on stop-now. `ST_TRN_STOPARM` goes back to `ST_TRN` on cancel-stop, and to `ST_IDLE` on stop-now or on a control-role match.

A sticky target-reached flag records matches that have an interrupt role. Writing a 1 to `status_clr` clears the flag, and the interrupt output is the flag gated by an enable.

Top module: `pps_pulse_ctrl`

## Requirements
- R1: After reset, `pps_out`, `irq`, `tgt_reached` and `cmd_echo` are all 0.
- R2: A command written with `cmd_wr` takes effect at the next clock edge. `cmd_echo` shows the written code for exactly one cycle after the write and then reads 0. Code 0 has no effect, and a code that does not apply in the current state is dropped.
- R3: Code 1 arms a single pulse. After the control-role match edge, `pps_out` is high for `width` cycles, starting in the cycle that follows that edge.
- R4: Code 2 arms a train. After the match, `pps_out` rises every `interval` cycles and stays high for `width` cycles each time (`width` < `interval`).
- R5: Code 3 given while a start is armed returns to idle, so no pulse follows the match.
- R6: Code 4 given during a train stops it at the next control-role match. Code 6 given before that match cancels the stop, and the train continues.
- R7: Code 5 ends a running pulse or train at once. `pps_out` is low from the second cycle after the write.
- R8: Target mode 0 and target mode 1 set `tgt_reached` on a match and never start or stop the output.
- R9: Target mode 2 uses a match both to set `tgt_reached` and to control the output. Target mode 3 uses a match only to control the output and never sets `tgt_reached`.
- R10: A match occurs when `time_now` >= the loaded target. Each `tgt_wr` load produces at most one match, including a target that is already in the past.
- R11: `tgt_reached` stays set until a cycle with `status_clr` = 1. `irq` equals `tgt_reached` AND `irq_en`.
- R12: With `width` = 0, no pulse is produced. A single-pulse start then returns straight to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_code | input | 3 | Command code (0 none, 1 single, 2 train, 3 cancel start, 4 stop at time, 5 stop now, 6 cancel stop) |
| cmd_echo | output | 3 | Readback of the command field; 0 once the command is accepted |
| tgt_wr | input | 1 | Loads `tgt_time` and arms one match |
| tgt_time | input | TIME_W | Target time value |
| tgt_mode | input | 2 | Target role: 0/1 interrupt only, 2 both, 3 control only |
| time_now | input | TIME_W | Free-running time counter |
| interval | input | CNT_W | Train period in cycles |
| width | input | CNT_W | High time in cycles |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Write-1-to-clear of `tgt_reached` |
| pps_out | output | 1 | Pulse output |
| irq | output | 1 | Interrupt |
| tgt_reached | output | 1 | Sticky target-reached status |

## Verification
Each start, stop and cancel path is driven against a known time counter, and a scoreboard compares the rise cycle and length of every pulse with the expected list. The single pulse checks the width count. The train checks that the interval wraps. A stop-at-time placed between two pulses checks that the stop takes effect on the match and not earlier. A stop-now given mid-pulse checks the truncation cycle. A cancel-stop followed by a command-0 write checks that the train keeps running. Each of the four target modes is run so that status-only matches can be told apart from control-only matches. A target loaded in the past, and a match left armed after its first firing, show the greater-or-equal compare and the single firing per load. A zero width shows that a start produces no pulse.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_ONE,
        ST_ARM_TRN,
        ST_ONE,
        ST_TRN,
        ST_TRN_STOPARM
    } pps_state_e;

    localparam logic [2:0] CMD_NONE        = 3'd0;
    localparam logic [2:0] CMD_START_ONE   = 3'd1;
    localparam logic [2:0] CMD_START_TRN   = 3'd2;
    localparam logic [2:0] CMD_CANCEL_STRT = 3'd3;
    localparam logic [2:0] CMD_STOP_AT     = 3'd4;
    localparam logic [2:0] CMD_STOP_NOW    = 3'd5;
    localparam logic [2:0] CMD_CANCEL_STOP = 3'd6;

    localparam logic [1:0] TM_IRQ_ONLY  = 2'd0;
    localparam logic [1:0] TM_FLAG_IRQ  = 2'd1;
    localparam logic [1:0] TM_BOTH      = 2'd2;
    localparam logic [1:0] TM_CTRL_ONLY = 2'd3;

endpackage

// File: rtl/pps_tgt_unit.sv
module pps_tgt_unit #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] tgt_in,
    input  logic [TIME_W-1:0] time_now,
    output logic              hit
);
    logic [TIME_W-1:0] tgt_q;
    logic              armed;

    assign hit = armed && (time_now >= tgt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
            armed <= 1'b0;
        end else if (load) begin
            tgt_q <= tgt_in;
            armed <= 1'b1;
        end else if (hit) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/pps_phase_gen.sv
module pps_phase_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             train,
    input  logic [CNT_W-1:0] interval,
    input  logic [CNT_W-1:0] width,
    output logic             pulse_lvl,
    output logic             last
);
    logic [CNT_W-1:0] ph;
    logic [CNT_W:0]   ph_inc;
    logic             wrap;

    assign ph_inc    = {1'b0, ph} + {{CNT_W{1'b0}}, 1'b1};
    assign wrap      = ph_inc >= {1'b0, interval};
    assign pulse_lvl = ph < width;
    assign last      = (width == '0) || (ph_inc == {1'b0, width});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (restart) begin
            ph <= '0;
        end else if (run) begin
            if (train && wrap) begin
                ph <= '0;
            end else begin
                ph <= ph_inc[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pps_status.sv
module pps_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/pps_pulse_ctrl.sv
module pps_pulse_ctrl
    import pps_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [2:0]        cmd_code,
    output logic [2:0]        cmd_echo,
    input  logic              tgt_wr,
    input  logic [TIME_W-1:0] tgt_time,
    input  logic [1:0]        tgt_mode,
    input  logic [TIME_W-1:0] time_now,
    input  logic [CNT_W-1:0]  interval,
    input  logic [CNT_W-1:0]  width,
    input  logic              irq_en,
    input  logic              status_clr,
    output logic              pps_out,
    output logic              irq,
    output logic              tgt_reached
);
    pps_state_e st, nxt;
    logic [2:0] cmd_q;
    logic       hit, hit_irq, hit_ctl;
    logic       restart, run, train, pulse_lvl, last;

    // command field: holds a write for one cycle, then reads back as 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_NONE;
        end else if (cmd_wr) begin
            cmd_q <= cmd_code;
        end else begin
            cmd_q <= CMD_NONE;
        end
    end

    pps_tgt_unit #(.TIME_W(TIME_W)) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tgt_wr),
        .tgt_in   (tgt_time),
        .time_now (time_now),
        .hit      (hit)
    );

    assign hit_irq = hit && (tgt_mode != TM_CTRL_ONLY);
    assign hit_ctl = hit && ((tgt_mode == TM_BOTH) || (tgt_mode == TM_CTRL_ONLY));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next-state logic: a command in the same cycle wins over a match
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_q == CMD_START_ONE)      nxt = ST_ARM_ONE;
                else if (cmd_q == CMD_START_TRN) nxt = ST_ARM_TRN;
            end
            ST_ARM_ONE: begin
                if (cmd_q == CMD_CANCEL_STRT) nxt = ST_IDLE;
                else if (hit_ctl)             nxt = ST_ONE;
            end
            ST_ARM_TRN: begin
                if (cmd_q == CMD_CANCEL_STRT) nxt = ST_IDLE;
                else if (hit_ctl)             nxt = ST_TRN;
            end
            ST_ONE: begin
                if (cmd_q == CMD_STOP_NOW || last) nxt = ST_IDLE;
            end
            ST_TRN: begin
                if (cmd_q == CMD_STOP_NOW)     nxt = ST_IDLE;
                else if (cmd_q == CMD_STOP_AT) nxt = ST_TRN_STOPARM;
            end
            ST_TRN_STOPARM: begin
                if (cmd_q == CMD_STOP_NOW)         nxt = ST_IDLE;
                else if (cmd_q == CMD_CANCEL_STOP) nxt = ST_TRN;
                else if (hit_ctl)                  nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign restart = ((st == ST_ARM_ONE) && (nxt == ST_ONE)) ||
                     ((st == ST_ARM_TRN) && (nxt == ST_TRN));

    pps_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .run       (run),
        .train     (train),
        .interval  (interval),
        .width     (width),
        .pulse_lvl (pulse_lvl),
        .last      (last)
    );

    pps_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hit_irq),
        .clr    (status_clr),
        .irq_en (irq_en),
        .flag   (tgt_reached),
        .irq    (irq)
    );

    // output decode
    always_comb begin
        run   = 1'b0;
        train = 1'b0;
        unique case (st)
            ST_ONE:         run = 1'b1;
            ST_TRN,
            ST_TRN_STOPARM: begin
                run   = 1'b1;
                train = 1'b1;
            end
            default: begin
                run   = 1'b0;
                train = 1'b0;
            end
        endcase
        pps_out  = run && pulse_lvl;
        cmd_echo = cmd_q;
    end
endmodule

// File: rtl/pps_pulse_ctrl_chk.sv
module pps_pulse_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [2:0]       cmd_echo,
    input logic [1:0]       tgt_mode,
    input logic             status_clr,
    input logic             tgt_reached,
    input logic [CNT_W-1:0] width,
    input logic             pps_out
);
    AST_ECHO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_echo != 3'd0 && !cmd_wr) |=> (cmd_echo == 3'd0)); // R2

    AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_echo == 3'd5 && pps_out) |=> !pps_out); // R7

    AST_CTRL_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_reached) |-> ($past(tgt_mode) != 2'd3)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_reached && !status_clr) |=> tgt_reached); // R11

    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (width == '0) |-> !pps_out); // R12
endmodule

bind pps_pulse_ctrl pps_pulse_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_echo    (cmd_echo),
    .tgt_mode    (tgt_mode),
    .status_clr  (status_clr),
    .tgt_reached (tgt_reached),
    .width       (width),
    .pps_out     (pps_out)
);

// File: tb/pps_pulse_ctrl_tb.sv
module pps_pulse_ctrl_tb;
    localparam int TW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [2:0]    cmd_echo;
    logic          tgt_wr = 1'b0;
    logic [TW-1:0] tgt_time = '0;
    logic [1:0]    tgt_mode = 2'd2;
    logic [TW-1:0] cyc = '0;
    logic [CW-1:0] interval = 16'd10;
    logic [CW-1:0] width = 16'd3;
    logic          irq_en = 1'b1;
    logic          status_clr = 1'b0;
    logic          pps_out, irq, tgt_reached;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int rise;
        int len;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pps_pulse_ctrl #(.TIME_W(TW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .cmd_echo(cmd_echo), .tgt_wr(tgt_wr), .tgt_time(tgt_time),
        .tgt_mode(tgt_mode), .time_now(cyc), .interval(interval),
        .width(width), .irq_en(irq_en), .status_clr(status_clr),
        .pps_out(pps_out), .irq(irq), .tgt_reached(tgt_reached)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int rise, input int len, input string req);
        exp_t e;
        e.rise = rise;
        e.len  = len;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (int'(cyc) < c) @(negedge clk);
    endtask

    // drive target load and/or command for one edge
    task automatic drive(input bit t, input int tv, input bit c, input logic [2:0] code);
        tgt_wr   = t;
        tgt_time = tv;
        cmd_wr   = c;
        cmd_code = code;
        @(negedge clk);
        tgt_wr = 1'b0;
        cmd_wr = 1'b0;
    endtask

    task automatic clear_flag();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    // monitor: measures each pulse and compares with the queue head
    int  rise_c = 0;
    bit  prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pps_out && !prev) rise_c = int'(cyc);
            if (!pps_out && prev) begin
                if (sb.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL pulse: unexpected pulse at %0d len %0d, expected none", rise_c, int'(cyc) - rise_c);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.req, " rise"}, rise_c, e.rise);
                    chk({e.req, " len"}, int'(cyc) - rise_c, e.len);
                end
            end
            prev = pps_out;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pps_out", pps_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tgt_reached", tgt_reached, 0);
        chk("R1 cmd_echo", cmd_echo, 0);

        // R3 single pulse, mode 2, with R2 echo
        tgt_mode = 2'd2;
        t = int'(cyc) + 20;
        push(t + 1, 3, "R3 single");
        drive(1, t, 1, 3'd1);
        chk("R2 echo shows code", cmd_echo, 1);
        @(negedge clk);
        chk("R2 echo cleared", cmd_echo, 0);
        wait_to(t + 1);
        chk("R9 mode2 sets flag", tgt_reached, 1);
        chk("R11 irq enabled", irq, 1);
        wait_to(t + 10);
        clear_flag();
        chk("R11 flag cleared", tgt_reached, 0);

        // R5 cancel armed start
        t = int'(cyc) + 20;
        drive(1, t, 1, 3'd2);
        drive(0, 0, 1, 3'd3);
        wait_to(t + 25);
        chk("R5 no pulse after cancel", pps_out, 0);
        clear_flag();

        // R4 train + R6 stop at time, mode 3
        tgt_mode = 2'd3;
        t = int'(cyc) + 20;
        for (int k = 0; k < 4; k++) push(t + 1 + 10 * k, 3, "R4/R6 train");
        drive(1, t, 1, 3'd2);
        wait_to(t + 25);
        drive(1, t + 35, 1, 3'd4);
        wait_to(t + 60);
        chk("R9 mode3 no flag", tgt_reached, 0);
        chk("R6 stopped at target", pps_out, 0);

        // R6 cancel stop, R2 code 0, R7 stop now, mode 2
        tgt_mode = 2'd2;
        t = int'(cyc) + 20;
        push(t + 1, 3, "R6 train");
        push(t + 11, 3, "R6 train after cancel");
        push(t + 21, 3, "R2 train after code0");
        push(t + 31, 2, "R7 truncated");
        drive(1, t, 1, 3'd2);
        wait_to(t + 5);
        drive(1, t + 15, 1, 3'd4);
        wait_to(t + 8);
        drive(0, 0, 1, 3'd6);
        wait_to(t + 12);
        drive(0, 0, 1, 3'd0);
        wait_to(t + 31);
        drive(0, 0, 1, 3'd5);
        wait_to(t + 50);
        chk("R7 stays low", pps_out, 0);
        clear_flag();

        // R8 mode 0: flag only, R11 gating
        tgt_mode = 2'd0;
        irq_en = 1'b0;
        t = int'(cyc) + 20;
        drive(1, t, 1, 3'd1);
        wait_to(t + 8);
        chk("R8 mode0 flag", tgt_reached, 1);
        chk("R11 irq masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R11 irq unmasked", irq, 1);
        drive(0, 0, 1, 3'd3);
        clear_flag();
        repeat (10) @(negedge clk);
        chk("R10 fires once", tgt_reached, 0);

        // R8/R10 mode 1, target already in the past
        tgt_mode = 2'd1;
        drive(1, int'(cyc) - 5, 0, 3'd0);
        @(negedge clk);
        chk("R10 past target matches", tgt_reached, 1);
        chk("R8 mode1 no pulse", pps_out, 0);
        clear_flag();

        // R12 zero width, then normal single to prove idle
        tgt_mode = 2'd3;
        width = 16'd0;
        t = int'(cyc) + 20;
        drive(1, t, 1, 3'd1);
        wait_to(t + 10);
        chk("R12 no pulse", pps_out, 0);
        width = 16'd3;
        t = int'(cyc) + 20;
        push(t + 1, 3, "R12 back to idle");
        drive(1, t, 1, 3'd1);
        wait_to(t + 15);

        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            n_bad++;
            $display("FAIL %s: actual missing pulse expected rise %0d", e.req, e.rise);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule